// File: doc/BRIEF.md
# Multi-Register Transfer Sequencer

This block expands a single multi-register move instruction into an ordered series of memory transfers. When it is started, it samples an instruction extension word and an addressing-mode flag. In the data-register mode it also samples the low bytes of the eight integer data registers, and in every mode it samples a start address. From these it works out which registers to move and in what order. It then issues one memory request at a time, each carrying the register index, the direction and the address. Each request waits for a memory acknowledge before the next one is issued.

There are two modes. In the data-register mode, up to eight 96-bit floating-point registers move as 12-byte blocks, with no format conversion and no effect on any status word. In the control-register mode, up to three 32-bit control registers move as 4-byte words. Before any transfer in the control-register mode, the block checks the operand against legality rules.

A run ends with a one-cycle `done` pulse. The pulse is qualified by `fault` (a transfer reported a memory fault) or `illegal` (the control-register operand was rejected). It also carries the final address, which the caller writes back to the address register. Effective-address decoding and data conversion are outside this block.

Top module: `rmx_seq`

## Requirements
- R1: Extension-word bit 13 gives the direction of every request in a run: 1 moves register contents to memory, 0 loads registers from memory (`req_to_mem`).
- R2: When extension-word bit 11 is 0, the data-register list is extension-word bits 7..0.
- R3: When extension-word bit 11 is 1, the data-register list is the low byte of the integer data register selected by extension-word bits 6..4 (`dreg_lo` byte n belongs to register n). The static list bits then have no effect.
- R4: The list is scanned from bit 7 down to bit 0. Without predecrement, list bit 7 selects register 0 and list bit 0 selects register 7, so the registers go out in ascending order.
- R5: With predecrement, list bit k selects register k, so the registers go out in descending order. Before each transfer the address is lowered by the transfer size, and the request carries the lowered address.
- R6: Without predecrement, each request carries the current address, and the address then rises by the transfer size. A data-register transfer is 12 bytes (`req_size`=12).
- R7: A request acknowledged with `mem_fault`=1 ends the run: no further request is issued, and `done` and `fault` pulse together. `final_addr` holds the address as it stood before the faulting transfer.
- R8: In the control-register mode, extension-word bits 12, 11 and 10 select the control word, the status word and the instruction-address register. These are moved in that order, as 4-byte transfers, with `req_ctl`=1 and `req_reg` equal to 2, 1 and 0 respectively.
- R9: In the control-register mode with a CPU-register-direct operand, any selection other than exactly one register is illegal.
- R10: In the control-register mode, a direct address-register operand is illegal when the control word or the status word is selected. The instruction-address register alone is legal with an address register.
- R11: An illegal operand or an empty list produces no request. `done` pulses on the cycle after `start`, with `final_addr` equal to `base_addr`. Otherwise `final_addr` is the address after the last transfer.
- R12: A request that is not acknowledged keeps `req_valid`, `req_reg`, `req_ctl` and `req_addr` unchanged.
- R13: After reset the block is idle, with no request, no `done` and no qualifiers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; accepted only while idle |
| ctl_mode | input | 1 | 1 selects the control-register mode |
| predec | input | 1 | Operand uses predecrement addressing |
| ea_direct | input | 1 | Operand is a CPU register, not memory |
| ea_areg | input | 1 | The direct register is an address register |
| ext_word | input | 16 | Instruction extension word |
| dreg_lo | input | 64 | Low bytes of integer data registers 0..7 |
| base_addr | input | 32 | Start address |
| mem_ack | input | 1 | Memory accepts the current request |
| mem_fault | input | 1 | Qualifies `mem_ack`: the transfer faulted |
| busy | output | 1 | A run is in progress |
| req_valid | output | 1 | A transfer request is presented |
| req_ctl | output | 1 | The request moves a control register |
| req_reg | output | 3 | Register index of the request |
| req_to_mem | output | 1 | Direction: 1 register to memory |
| req_addr | output | 32 | Transfer address |
| req_size | output | 4 | Transfer size in bytes |
| done | output | 1 | One-cycle end-of-run pulse |
| fault | output | 1 | With `done`: a transfer faulted |
| illegal | output | 1 | With `done`: the operand was rejected |
| final_addr | output | 32 | With `done`: address for writeback |

## Verification
A wrong entry in the pending-register mask appears at the very next acknowledged request: the following `req_reg` is out of order or repeated, or the run ends early or late. A wrong address register appears one request later as a `req_addr` that is off by a multiple of 12 or 4, and at the end as a wrong `final_addr`. A wrong mode or predecrement latch shows up on the first request, as a mirrored register order or a wrong transfer size. The sweep covers every 8-bit list in both walk directions, from both list sources. It also covers every control-register selection against every operand kind, so each of these faults is visible within one run.

// File: rtl/rmx_pkg.sv
package rmx_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } rmx_state_e;

  // Scan slots used by the control-register mode
  localparam int unsigned CTL_SLOTS = 3;
endpackage

// File: rtl/rmx_list_build.sv
module rmx_list_build #(
  parameter int unsigned NREG = 8
) (
  input  logic                 ctl_mode,
  input  logic [15:0]          ext_word,
  input  logic [NREG*NREG-1:0] dreg_lo,
  output logic [NREG-1:0]      slot_mask
);
  localparam int unsigned IW = $clog2(NREG);

  logic [NREG-1:0] dreg_arr [NREG];
  logic [NREG-1:0] list;
  logic [NREG-1:0] data_mask;
  logic [NREG-1:0] ctl_mask;
  logic [IW-1:0]   dsel;
  logic            unused_ext;

  assign unused_ext = ^{ext_word[15:14], ext_word[9:8]};
  assign dsel       = ext_word[4 +: IW];

  for (genvar g = 0; g < NREG; g++) begin : g_dreg
    assign dreg_arr[g] = dreg_lo[g*NREG +: NREG];
    // slot g takes list bit NREG-1-g: the scan runs from the top bit down
    assign data_mask[g] = list[NREG-1-g];
  end

  assign list = ext_word[11] ? dreg_arr[dsel] : ext_word[NREG-1:0];

  always_comb begin
    ctl_mask    = '0;
    ctl_mask[0] = ext_word[12];
    ctl_mask[1] = ext_word[11];
    ctl_mask[2] = ext_word[10];
  end

  assign slot_mask = ctl_mode ? ctl_mask : data_mask;
endmodule

// File: rtl/rmx_first_pick.sv
module rmx_first_pick #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0]         mask,
  output logic                 found,
  output logic [$clog2(N)-1:0] idx,
  output logic [N-1:0]         rest
);
  localparam int unsigned IW = $clog2(N);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

  always_comb begin
    rest = mask;
    for (int i = 0; i < N; i++) begin
      if (found && (IW'(i) == idx)) rest[i] = 1'b0;
    end
  end
endmodule

// File: rtl/rmx_addr_step.sv
module rmx_addr_step #(
  parameter int unsigned AW = 32,
  parameter int unsigned SW = 4
) (
  input  logic [AW-1:0] cur,
  input  logic          predec,
  input  logic [SW-1:0] size,
  output logic [AW-1:0] xfer_addr,
  output logic [AW-1:0] after_addr
);
  logic [AW-1:0] lowered;

  assign lowered    = cur - AW'(size);
  assign xfer_addr  = predec ? lowered : cur;
  assign after_addr = predec ? lowered : cur + AW'(size);
endmodule

// File: rtl/rmx_seq.sv
module rmx_seq #(
  parameter int unsigned NREG   = 8,
  parameter int unsigned AW     = 32,
  parameter int unsigned DBYTES = 12,
  parameter int unsigned CBYTES = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic                       ctl_mode,
  input  logic                       predec,
  input  logic                       ea_direct,
  input  logic                       ea_areg,
  input  logic [15:0]                ext_word,
  input  logic [NREG*NREG-1:0]       dreg_lo,
  input  logic [AW-1:0]              base_addr,
  input  logic                       mem_ack,
  input  logic                       mem_fault,
  output logic                       busy,
  output logic                       req_valid,
  output logic                       req_ctl,
  output logic [$clog2(NREG)-1:0]    req_reg,
  output logic                       req_to_mem,
  output logic [AW-1:0]              req_addr,
  output logic [$clog2(DBYTES+1)-1:0] req_size,
  output logic                       done,
  output logic                       fault,
  output logic                       illegal,
  output logic [AW-1:0]              final_addr
);
  import rmx_pkg::*;

  localparam int unsigned IW = $clog2(NREG);
  localparam int unsigned SW = $clog2(DBYTES + 1);

  rmx_state_e    state_q;
  logic          ctl_q, pd_q;
  logic [NREG-1:0] mask_q;
  logic [AW-1:0] cur_q;

  logic          idle;
  logic          mode_eff, pd_eff;
  logic [SW-1:0] size_eff;
  logic [NREG-1:0] built_mask, pick_in, pick_rest;
  logic          pick_found;
  logic [IW-1:0] pick_idx, pick_reg;
  logic [AW-1:0] cur_xfer, cur_after, next_base, next_xfer, next_after;
  logic [2:0]    csel;
  logic          bad_operand;
  logic          unused_step;

  assign idle     = (state_q == ST_IDLE);
  assign busy     = ~idle;
  assign mode_eff = idle ? ctl_mode : ctl_q;
  assign pd_eff   = idle ? predec : pd_q;
  assign size_eff = mode_eff ? SW'(CBYTES) : SW'(DBYTES);

  rmx_list_build #(.NREG(NREG)) u_list (
    .ctl_mode  (ctl_mode),
    .ext_word  (ext_word),
    .dreg_lo   (dreg_lo),
    .slot_mask (built_mask)
  );

  assign pick_in = idle ? built_mask : mask_q;

  rmx_first_pick #(.N(NREG)) u_pick (
    .mask  (pick_in),
    .found (pick_found),
    .idx   (pick_idx),
    .rest  (pick_rest)
  );

  // register index for the picked slot
  always_comb begin
    if (mode_eff)    pick_reg = IW'(CTL_SLOTS - 1) - pick_idx;
    else if (pd_eff) pick_reg = IW'(NREG - 1) - pick_idx;
    else             pick_reg = pick_idx;
  end

  // address after the transfer in flight
  rmx_addr_step #(.AW(AW), .SW(SW)) u_step_cur (
    .cur        (cur_q),
    .predec     (pd_q),
    .size       (size_eff),
    .xfer_addr  (cur_xfer),
    .after_addr (cur_after)
  );

  assign next_base = idle ? base_addr : cur_after;

  // address of the next transfer to issue
  rmx_addr_step #(.AW(AW), .SW(SW)) u_step_next (
    .cur        (next_base),
    .predec     (pd_eff),
    .size       (size_eff),
    .xfer_addr  (next_xfer),
    .after_addr (next_after)
  );

  assign unused_step = ^{cur_xfer, next_after};

  assign csel        = ext_word[12:10];
  assign bad_operand = ctl_mode && ea_direct &&
                       (($countones(csel) != 1) || (ea_areg && (csel[2] || csel[1])));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      ctl_q      <= 1'b0;
      pd_q       <= 1'b0;
      mask_q     <= '0;
      cur_q      <= '0;
      req_valid  <= 1'b0;
      req_ctl    <= 1'b0;
      req_reg    <= '0;
      req_to_mem <= 1'b0;
      req_addr   <= '0;
      req_size   <= '0;
      done       <= 1'b0;
      fault      <= 1'b0;
      illegal    <= 1'b0;
      final_addr <= '0;
    end else begin
      done    <= 1'b0;
      fault   <= 1'b0;
      illegal <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            ctl_q      <= ctl_mode;
            pd_q       <= predec;
            req_to_mem <= ext_word[13];
            cur_q      <= base_addr;
            if (bad_operand) begin
              done       <= 1'b1;
              illegal    <= 1'b1;
              final_addr <= base_addr;
            end else if (!pick_found) begin
              done       <= 1'b1;
              final_addr <= base_addr;
            end else begin
              state_q   <= ST_XFER;
              req_valid <= 1'b1;
              req_ctl   <= ctl_mode;
              req_reg   <= pick_reg;
              req_addr  <= next_xfer;
              req_size  <= size_eff;
              mask_q    <= pick_rest;
            end
          end
        end
        ST_XFER: begin
          if (mem_ack) begin
            if (mem_fault) begin
              state_q    <= ST_IDLE;
              req_valid  <= 1'b0;
              done       <= 1'b1;
              fault      <= 1'b1;
              final_addr <= cur_q;
            end else if (!pick_found) begin
              state_q    <= ST_IDLE;
              req_valid  <= 1'b0;
              done       <= 1'b1;
              final_addr <= cur_after;
            end else begin
              req_reg  <= pick_reg;
              req_addr <= next_xfer;
              mask_q   <= pick_rest;
              cur_q    <= cur_after;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rmx_seq_chk.sv
module rmx_seq_chk #(
  parameter int unsigned IW     = 3,
  parameter int unsigned AW     = 32,
  parameter int unsigned SW     = 4,
  parameter int unsigned DBYTES = 12,
  parameter int unsigned CBYTES = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          req_valid,
  input logic          req_ctl,
  input logic [IW-1:0] req_reg,
  input logic [AW-1:0] req_addr,
  input logic [SW-1:0] req_size,
  input logic          mem_ack,
  input logic          mem_fault,
  input logic          done,
  input logic          fault,
  input logic          illegal
);
  // R12: an unacknowledged request is held unchanged
  a_r12_hold_request: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !mem_ack) |=> (req_valid && $stable(req_addr) && $stable(req_reg) && $stable(req_ctl)));

  // R7: a faulting acknowledge ends the run at once
  a_r7_fault_stops: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mem_ack && mem_fault) |=> (!req_valid && done && fault));

  // R7: fault is only a qualifier of done
  a_r7_fault_with_done: assert property (@(posedge clk) disable iff (rst)
    fault |-> done);

  // R9: a rejected operand finishes on the cycle after an accepted start
  a_r9_illegal_prompt: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (done && !fault && $past(start && !busy)));

  // R8: transfer size follows the register class
  a_r8_size_by_class: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_size == (req_ctl ? SW'(CBYTES) : SW'(DBYTES))));

  // R11: completion and a pending request never coincide
  a_r11_done_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(done && req_valid));
endmodule

bind rmx_seq rmx_seq_chk #(
  .IW($clog2(NREG)), .AW(AW), .SW($clog2(DBYTES+1)), .DBYTES(DBYTES), .CBYTES(CBYTES)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .req_valid(req_valid),
  .req_ctl(req_ctl), .req_reg(req_reg), .req_addr(req_addr), .req_size(req_size),
  .mem_ack(mem_ack), .mem_fault(mem_fault), .done(done), .fault(fault), .illegal(illegal)
);

// File: tb/rmx_seq_bench.sv
module rmx_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, ctl_mode = 1'b0, predec = 1'b0, ea_direct = 1'b0, ea_areg = 1'b0;
  logic [15:0] ext_word = '0;
  logic [63:0] dreg_lo = '0;
  logic [31:0] base_addr = '0;
  logic        mem_ack = 1'b0, mem_fault = 1'b0;
  logic        busy, req_valid, req_ctl, req_to_mem, done, fault, illegal;
  logic [2:0]  req_reg;
  logic [31:0] req_addr, final_addr;
  logic [3:0]  req_size;

  always #10 clk = ~clk;

  rmx_seq u_rmx_seq (
    .clk(clk), .rst(rst), .start(start), .ctl_mode(ctl_mode), .predec(predec),
    .ea_direct(ea_direct), .ea_areg(ea_areg), .ext_word(ext_word), .dreg_lo(dreg_lo),
    .base_addr(base_addr), .mem_ack(mem_ack), .mem_fault(mem_fault), .busy(busy),
    .req_valid(req_valid), .req_ctl(req_ctl), .req_reg(req_reg), .req_to_mem(req_to_mem),
    .req_addr(req_addr), .req_size(req_size), .done(done), .fault(fault),
    .illegal(illegal), .final_addr(final_addr)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run_case(input bit cm, input bit pd, input bit dr, input bit ar,
                          input logic [15:0] ext, input logic [63:0] dregs,
                          input logic [31:0] base, input int fault_at, input bit hold);
    logic [7:0]  list;
    bit          e_ctl [8];
    int          e_reg [8];
    logic [31:0] e_addr [8];
    logic [31:0] e_before [8];
    int          n = 0;
    int          k = 0;
    int          sz;
    logic [31:0] cur;
    logic [31:0] e_final;
    bit          bad;
    bit          e_fault;
    string       ordtag, adrtag;
    logic [31:0] h_addr;
    logic [2:0]  h_reg;

    sz     = cm ? 4 : 12;
    cur    = base;
    ordtag = cm ? "R8" : (pd ? "R5" : "R4");
    adrtag = pd ? "R5" : "R6";
    bad    = cm && dr && (($countones(ext[12:10]) != 1) || (ar && (ext[12] || ext[11])));
    list   = ext[11] ? dregs[ext[6:4]*8 +: 8] : ext[7:0];
    if (!bad) begin
      for (int i = 0; i < (cm ? 3 : 8); i++) begin
        bit sel;
        sel = cm ? ext[12-i] : list[7-i];
        if (sel) begin
          e_ctl[n]    = cm;
          e_reg[n]    = cm ? 2 - i : (pd ? 7 - i : i);
          e_before[n] = cur;
          if (pd) cur = cur - sz;
          e_addr[n] = cur;
          if (!pd) cur = cur + sz;
          n++;
        end
      end
    end
    e_fault = (fault_at >= 0) && (fault_at < n);
    e_final = e_fault ? e_before[fault_at] : cur;
    if (e_fault) n = fault_at + 1;

    @(negedge clk);
    ctl_mode = cm; predec = pd; ea_direct = dr; ea_areg = ar;
    ext_word = ext; dreg_lo = dregs; base_addr = base; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc < 40; cyc++) begin
      if (done) break;
      if (req_valid) begin
        chk(k < n, n == 0 ? "R11" : ordtag, k, n);
        if (k < n) begin
          chk(req_reg == e_reg[k][2:0], ext[11] && !cm ? "R3" : ordtag, req_reg, e_reg[k]);
          chk(req_ctl == e_ctl[k], "R8", req_ctl, e_ctl[k]);
          chk(req_addr == e_addr[k], adrtag, req_addr, e_addr[k]);
          chk(req_size == sz, cm ? "R8" : "R6", req_size, sz);
          chk(req_to_mem == ext[13], "R1", req_to_mem, ext[13]);
        end
        if (hold && k == 0) begin
          h_addr = req_addr; h_reg = req_reg;
          @(negedge clk);
          chk(req_valid && req_addr == h_addr && req_reg == h_reg, "R12", req_addr, h_addr);
        end
        mem_ack = 1'b1;
        mem_fault = (k == fault_at);
        @(negedge clk);
        mem_ack = 1'b0;
        mem_fault = 1'b0;
        k++;
      end else begin
        @(negedge clk);
      end
    end
    chk(done == 1'b1, "R11", done, 1);
    chk(k == n, e_fault ? "R7" : (n == 0 ? "R11" : ordtag), k, n);
    chk(illegal == bad, (cm && ar) ? "R10" : "R9", illegal, bad);
    chk(fault == e_fault, "R7", fault, e_fault);
    chk(final_addr == e_final, e_fault ? "R7" : "R11", final_addr, e_final);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !req_valid && !done && !fault && !illegal, "R13",
        {busy, req_valid, done, fault, illegal}, 0);

    // data mode, static list (R2), every list, both walk directions
    for (int l = 0; l < 256; l++) begin
      for (int p = 0; p < 2; p++) begin
        logic [15:0] e;
        e = {2'b00, l[0], l[1], 1'b0, 3'b000, l[7:0]};
        run_case(1'b0, p[0], 1'b0, 1'b0, e, {$urandom, $urandom},
                 32'h0001_0000 + 32'(l) * 32'h100, -1, l == 8'h5A);
      end
    end

    // data mode, dynamic list from a data register (R3); static bits differ
    for (int l = 0; l < 256; l++) begin
      for (int p = 0; p < 2; p++) begin
        logic [15:0] e;
        logic [63:0] d;
        logic [2:0]  ix;
        ix = 3'(l + p);
        d  = {$urandom, $urandom};
        d[ix*8 +: 8] = 8'(l);
        e  = {2'b00, l[2], 1'b0, 1'b1, 3'b000, ~l[7], ix, ~l[3:0]};
        run_case(1'b0, p[0], 1'b0, 1'b0, e, d, 32'h0004_0000, -1, 1'b0);
      end
    end

    // faults part-way (R7)
    run_case(1'b0, 1'b0, 1'b0, 1'b0, 16'h20FF, '0, 32'h0000_8000, 0, 1'b0);
    run_case(1'b0, 1'b0, 1'b0, 1'b0, 16'h00FF, '0, 32'h0000_8000, 3, 1'b0);
    run_case(1'b0, 1'b1, 1'b0, 1'b0, 16'h2096, '0, 32'h0000_8000, 2, 1'b0);
    run_case(1'b1, 1'b1, 1'b0, 1'b0, 16'h1C00, '0, 32'h0000_9000, 1, 1'b0);

    // control-register mode: every selection against every operand kind (R8, R9, R10)
    for (int s = 0; s < 8; s++) begin
      for (int v = 0; v < 16; v++) begin
        logic [15:0] e;
        e = {2'b00, v[3], s[2:0], 10'h0A5};
        run_case(1'b1, v[0], v[1], v[2], e, '0, 32'h0002_0000, -1, s == 7 && v == 0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule